// File: doc/BRIEF.md
# Parity-Alternating Up/Down Counter

This block is a small synchronous counter that steps by two instead of by one. It walks through all the even codes first, then all the odd codes, then returns to the even codes. The pattern repeats for as long as the counter is enabled. A direction select runs the same cycle forwards or backwards, so the down sequence is the exact mirror of the up sequence. Every one of the sixteen 4-bit codes is visited once per full lap.

Typical uses are interleaved addressing, where even and odd banks are swept in separate half-laps, and test patterns that need a fixed visiting order. The count comes straight from a register.

Reset is synchronous and active high. A low enable freezes the count. The width is a package parameter with a default of 4 bits; the requirements below are written for that default.

Top module: `eo_updown_counter`

## Requirements
- R1: When `rst` is 1 at a rising clock edge, `count` is 0000 after that edge, whatever `cnt_en` and `dir_up` are.
- R2: When `rst` is 0 and `cnt_en` is 0 at a rising edge, `count` keeps its value across that edge.
- R3: When counting up (`dir_up` = 1, `cnt_en` = 1), a value below the top of its parity class (anything other than 14 or 15) advances by exactly 2.
- R4: When counting up, 14 (the highest even code) is followed by 1, and 15 (the highest odd code) is followed by 0.
- R5: When counting down (`dir_up` = 0, `cnt_en` = 1), a value above the bottom of its parity class (anything other than 0 or 1) drops by exactly 2.
- R6: When counting down, 1 (the lowest odd code) is followed by 14, and 0 (the lowest even code) is followed by 15.
- R7: A change of `dir_up` takes effect at the next enabled edge. The count moves from its current value to that value's neighbour in the new direction, with no extra step and no skipped step.
- R8: Sixteen consecutive enabled steps in one direction visit each of the sixteen codes exactly once and return to the starting value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; takes priority over the enable |
| cnt_en | input | 1 | Count enable; 0 holds the count |
| dir_up | input | 1 | Direction: 1 counts up, 0 counts down |
| count | output | 4 | Registered count value |

## Verification
The assertions assume `rst` is held high from time zero through at least one rising edge. They also assume `cnt_en` and `dir_up` are known, non-X values at every edge after reset. The bench meets both assumptions by asserting reset before the first edge and by driving every control input only on falling edges, always to defined levels. The stimulus mixes long runs in each direction, wraps at both class boundaries, direction flips next to those boundaries, enable gaps, and a reset applied in the middle of counting.

// File: rtl/eo_counter_pkg.sv
package eo_counter_pkg;
  parameter int CNT_W = 4;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;
endpackage

// File: rtl/eo_step_unit.sv
// Combinational neighbour computation: both directions are produced in parallel.
module eo_step_unit
  import eo_counter_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt_up,
  output logic [W-1:0] nxt_dn
);
  localparam logic [W-1:0] STRIDE = W'(2);

  logic at_class_top;
  logic at_class_bot;

  // Parity is the LSB; position within the class is held in the upper bits.
  assign at_class_top = &cur[W-1:1];
  assign at_class_bot = ~|cur[W-1:1];

  always_comb begin
    if (at_class_top) begin
      nxt_up = {{(W-1){1'b0}}, ~cur[0]};
    end else begin
      nxt_up = cur + STRIDE;
    end
    if (at_class_bot) begin
      nxt_dn = {{(W-1){1'b1}}, ~cur[0]};
    end else begin
      nxt_dn = cur - STRIDE;
    end
  end
endmodule

// File: rtl/eo_count_reg.sv
// State register: synchronous reset first, then enable-gated load.
module eo_count_reg
  import eo_counter_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= d;
    end
  end
endmodule

// File: rtl/eo_updown_counter.sv
module eo_updown_counter
  import eo_counter_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             dir_up,
  output logic [CNT_W-1:0] count
);
  cnt_t cur_q;
  cnt_t step_up;
  cnt_t step_dn;
  cnt_t next_val;
  dir_e dir_sel;

  assign dir_sel = dir_e'(dir_up);

  eo_step_unit #(.W(CNT_W)) u_step (
    .cur    (cur_q),
    .nxt_up (step_up),
    .nxt_dn (step_dn)
  );

  always_comb begin
    unique case (dir_sel)
      DIR_UP:   next_val = step_up;
      default:  next_val = step_dn;
    endcase
  end

  eo_count_reg #(.W(CNT_W)) u_reg (
    .clk  (clk),
    .rst  (rst),
    .load (cnt_en),
    .d    (next_val),
    .q    (cur_q)
  );

  assign count = cur_q;
endmodule

// File: rtl/eo_updown_counter_chk.sv
module eo_updown_counter_chk
  import eo_counter_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             cnt_en,
  input logic             dir_up,
  input logic [CNT_W-1:0] count
);
  localparam cnt_t TWO     = CNT_W'(2);
  localparam cnt_t TOP_EV  = {{(CNT_W-1){1'b1}}, 1'b0};
  localparam cnt_t TOP_OD  = {CNT_W{1'b1}};
  localparam cnt_t BOT_EV  = '0;
  localparam cnt_t BOT_OD  = CNT_W'(1);

  bit rst_seen_q;
  always_ff @(posedge clk) rst_seen_q <= rst;

  // R1: after a reset edge the count reads zero
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
    rst_seen_q |-> count == '0);

  // R2: disabled edges leave the count untouched
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(count));

  // R3: up step inside a class adds two
  a_r3_up_step: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && dir_up && count != TOP_EV && count != TOP_OD)
      |=> cnt_t'(count - $past(count)) == TWO);

  // R4: up wrap hops to the other class
  a_r4_up_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && dir_up && (count == TOP_EV || count == TOP_OD))
      |=> count == ($past(count) == TOP_EV ? BOT_OD : BOT_EV));

  // R5: down step inside a class subtracts two
  a_r5_dn_step: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !dir_up && count != BOT_EV && count != BOT_OD)
      |=> cnt_t'($past(count) - count) == TWO);

  // R6: down wrap hops to the other class
  a_r6_dn_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !dir_up && (count == BOT_EV || count == BOT_OD))
      |=> count == ($past(count) == BOT_OD ? TOP_EV : TOP_OD));
endmodule

bind eo_updown_counter eo_updown_counter_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .cnt_en (cnt_en),
  .dir_up (dir_up),
  .count  (count)
);

// File: tb/test_eo_updown_counter.sv
`timescale 1ns/1ps
module test_eo_updown_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_en = 1'b0;
  logic       dir_up = 1'b1;
  logic [3:0] count;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int order[16];
  int pos = 0;

  always #2 clk = ~clk;

  eo_updown_counter i_eo_updown_counter (
    .clk    (clk),
    .rst    (rst),
    .cnt_en (cnt_en),
    .dir_up (dir_up),
    .count  (count)
  );

  function automatic string auto_tag(bit r, bit e, bit u, int p);
    if (r) return "R1";
    if (!e) return "R2";
    if (u) return (p == 7 || p == 15) ? "R4" : "R3";
    return (p == 0 || p == 8) ? "R6" : "R5";
  endfunction

  task automatic check_val(string tag, int exp);
    checks++;
    if (int'(count) != exp) begin
      errors++;
      $display("FAIL %s: count=%0d expected=%0d", tag, count, exp);
    end
  endtask

  // Drive on the falling edge, let one rising edge pass, compare on the next falling edge.
  task automatic step(bit r, bit e, bit u, string over);
    string tag;
    rst = r; cnt_en = e; dir_up = u;
    tag = (over != "") ? over : auto_tag(r, e, u, pos);
    @(posedge clk);
    @(negedge clk);
    if (r) pos = 0;
    else if (e) pos = u ? (pos + 1) % 16 : (pos + 15) % 16;
    check_val(tag, order[pos]);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) order[i] = (i < 8) ? 2 * i : 2 * (i - 8) + 1;
    @(negedge clk);
    step(1, 1, 1, "R1");
    step(1, 0, 0, "R1");
    // Full up lap with visit tracking
    begin
      bit [15:0] seen = '0;
      int dup = 0;
      for (int i = 0; i < 16; i++) begin
        step(0, 1, 1, "");
        if (seen[count]) dup++;
        seen[count] = 1'b1;
      end
      checks++;
      if (dup != 0 || seen != 16'hFFFF || count != 4'd0) begin
        errors++;
        $display("FAIL R8: up lap seen=%h dup=%0d end=%0d expected=ffff 0 0", seen, dup, count);
      end
    end
    // Full down lap with visit tracking
    begin
      bit [15:0] seen = '0;
      int dup = 0;
      for (int i = 0; i < 16; i++) begin
        step(0, 1, 0, "");
        if (seen[count]) dup++;
        seen[count] = 1'b1;
      end
      checks++;
      if (dup != 0 || seen != 16'hFFFF || count != 4'd0) begin
        errors++;
        $display("FAIL R8: down lap seen=%h dup=%0d end=%0d expected=ffff 0 0", seen, dup, count);
      end
    end
    // Holds in various positions and directions
    for (int i = 0; i < 5; i++) step(0, 1, 1, "");
    step(0, 0, 1, "R2");
    step(0, 0, 0, "R2");
    step(0, 0, 1, "R2");
    // Direction flips, including at class boundaries
    step(0, 1, 0, "R7");
    step(0, 1, 1, "R7");
    for (int i = 0; i < 3; i++) step(0, 1, 1, "");
    step(0, 1, 0, "R7");
    step(0, 1, 1, "R7");
    step(0, 1, 1, "R7");
    step(0, 1, 0, "R7");
    // Alternating pattern with enable gaps
    for (int i = 0; i < 40; i++) step(0, (i % 3) != 0, (i % 7) < 4, "");
    // Reset in the middle of counting
    step(1, 1, 0, "R1");
    step(0, 1, 0, "R6");
    step(0, 1, 0, "R5");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule